// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the transfer datapath of a single DMA channel. Software loads a 16-bit start address, a 16-bit count and an 8-bit page value. After that, each step strobe marks one transfer cycle. For that cycle the block gives the physical bus address, and it then moves the address forward by one and the count back by one.

The count holds the number of transfers minus one. Terminal count is signalled on the transfer that takes the count from zero to 0xFFFF. At that point there are two outcomes:
- With automatic reload selected, the channel reloads its starting values and stays armed.
- Otherwise the channel masks itself.

A byte channel forms a 24-bit byte address inside a 64K window. A word channel moves 16 bits per transfer inside a 128K window. The low 16 address bits never carry into the page.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset `cur_count` is 0, `phys_addr` is 0, `tc` is 0 and `active` is 0.
- R2: A cycle with `load` high copies `base_addr`, `base_count` and `base_page` into the channel. It also latches `word_mode` and `autoinit` as the channel mode and sets `active`. All of these are visible from the next cycle.
- R3: In byte mode (latched `word_mode` = 0), `phys_addr` equals {page[7:0], address[15:0]}.
- R4: In word mode (latched `word_mode` = 1), `phys_addr` equals {page[7:1], address[15:0], 1'b0}. Page bit 0 has no effect and bit 0 of `phys_addr` is always 0.
- R5: Each accepted step increments the 16-bit address by one. The address wraps from 0xFFFF to 0x0000 and the page bits do not change.
- R6: Each accepted step decrements `cur_count` by one. A step accepted while `cur_count` is 0x0000 is the final transfer. In that same cycle `tc` is high for one cycle, and `phys_addr` still shows the final transfer's address.
- R7: Without autoinit, the final transfer leaves `cur_count` at 0xFFFF and clears `active`. Later steps change neither the count nor the address.
- R8: With autoinit, the final transfer restores the address and count to their loaded values and `active` stays high.
- R9: When `load` and `step` are high in the same cycle, the load wins and no decrement is applied.
- R10: A step while `active` is low is ignored and `tc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Load base values and arm the channel |
| base_addr | input | 16 | Starting address (bytes or words) |
| base_count | input | 16 | Transfers minus one |
| base_page | input | 8 | Page value |
| word_mode | input | 1 | 1 selects a 16-bit word channel, latched on load |
| autoinit | input | 1 | 1 reloads on terminal count, latched on load |
| step | input | 1 | One transfer cycle |
| phys_addr | output | 24 | Physical address of the current transfer |
| tc | output | 1 | Terminal count pulse |
| cur_count | output | 16 | Current remaining count minus one |
| active | output | 1 | Channel armed (not masked) |

## Verification
The bench drives the address across 0xFFFF in both byte and word mode. A design that let the carry reach the page would show the page moving up by one instead of the low bits wrapping to zero. A one-transfer count of 0x0000 checks that terminal count fires on the very first step. An off-by-one design would either wait 65536 transfers or pulse one step early. The bench also steps again after a self-masked terminal count, steps before any load, and raises load and step together. Each of these exposes a design that keeps counting when it should hold, or that lets the step win over the load.

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] base_count,
  input  logic [PW-1:0] base_page,
  input  logic          word_mode,
  input  logic          autoinit,
  input  logic          step,
  output logic [PW+AW-1:0] phys_addr,
  output logic          tc,
  output logic [AW-1:0] cur_count,
  output logic          active
);
  logic [AW-1:0] base_addr_q, base_cnt_q, cur_addr;
  logic [PW-1:0] page_q;
  logic          mode_word, mode_auto;

  wire go   = step & active & ~load;
  wire last = (cur_count == '0);

  assign tc        = go & last;
  assign phys_addr = mode_word ? {page_q[PW-1:1], cur_addr, 1'b0}
                               : {page_q, cur_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr    <= '0;
      cur_count   <= '0;
      page_q      <= '0;
      mode_word   <= 1'b0;
      mode_auto   <= 1'b0;
      active      <= 1'b0;
    end else if (load) begin
      base_addr_q <= base_addr;
      base_cnt_q  <= base_count;
      cur_addr    <= base_addr;
      cur_count   <= base_count;
      page_q      <= base_page;
      mode_word   <= word_mode;
      mode_auto   <= autoinit;
      active      <= 1'b1;
    end else if (go) begin
      if (last && mode_auto) begin
        cur_addr  <= base_addr_q;
        cur_count <= base_cnt_q;
      end else begin
        cur_addr  <= cur_addr + 1'b1;
        cur_count <= cur_count - 1'b1;
        if (last) active <= 1'b0;
      end
    end
  end
endmodule

module dma_addr_seq_chk #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          step,
  input logic [AW-1:0] base_count,
  input logic [AW-1:0] base_cnt_q,
  input logic          mode_auto,
  input logic          mode_word,
  input logic [PW+AW-1:0] phys_addr,
  input logic          tc,
  input logic [AW-1:0] cur_count,
  input logic          active
);
  a_r2_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active && cur_count == $past(base_count));

  a_r4_even_word: assert property (@(posedge clk) disable iff (!rst_n)
    mode_word |-> phys_addr[0] == 1'b0);

  a_r6_tc_final: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> step && active && !load && cur_count == '0);

  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active && !load && cur_count != '0) |=> cur_count == $past(cur_count) - 1'b1);

  a_r7_self_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !mode_auto) |=> !active && cur_count == '1);

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && mode_auto) |=> active && cur_count == $past(base_cnt_q));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> !active && $stable(cur_count) && $stable(phys_addr));
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.AW(AW), .PW(PW)) chk (.*);

// File: tb/dma_addr_seq_test.sv
module dma_addr_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        load = 1'b0, step = 1'b0, word_mode = 1'b0, autoinit = 1'b0;
  logic [15:0] base_addr = '0, base_count = '0;
  logic [7:0]  base_page = '0;
  logic [23:0] phys_addr;
  logic        tc, active;
  logic [15:0] cur_count;
  int runs = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_addr_seq uut (.*);

  // {word, page, addr, count, steps, exp_phys, exp_count}
  localparam logic [84:0] VEC [4] = '{
    {1'b0, 8'h12, 16'h1234, 16'h0010, 4'd3, 24'h121237, 16'h000D},
    {1'b1, 8'h35, 16'h8000, 16'h0005, 4'd2, 24'h350004, 16'h0003},
    {1'b0, 8'h7F, 16'hFFFE, 16'h0010, 4'd3, 24'h7F0001, 16'h000D},
    {1'b1, 8'h02, 16'hFFFF, 16'h0008, 4'd1, 24'h020000, 16'h0007}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic w, input logic a, input logic [7:0] p,
                         input logic [15:0] ad, input logic [15:0] c);
    load = 1; word_mode = w; autoinit = a; base_page = p; base_addr = ad; base_count = c;
    @(negedge clk);
    load = 0;
  endtask

  task automatic do_steps(input int n);
    for (int i = 0; i < n; i++) begin
      step = 1;
      @(negedge clk);
      step = 0;
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 count", 32'(cur_count), 0);
    chk("R1 phys", 32'(phys_addr), 0);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 active", 32'(active), 0);
    rst_n = 1;
    @(negedge clk);

    step = 1; #1;
    chk("R10 tc idle", 32'(tc), 0);
    @(negedge clk); step = 0;
    chk("R10 count held", 32'(cur_count), 0);
    chk("R10 still inactive", 32'(active), 0);

    for (int k = 0; k < 4; k++) begin
      do_load(VEC[k][84], 1'b0, VEC[k][83:76], VEC[k][75:60], VEC[k][59:44]);
      chk("R2 armed", 32'(active), 1);
      chk("R2 count loaded", 32'(cur_count), 32'(VEC[k][59:44]));
      do_steps(int'(VEC[k][43:40]));
      chk(VEC[k][84] ? "R4 R5 word phys" : "R3 R5 byte phys", 32'(phys_addr), 32'(VEC[k][39:16]));
      chk("R6 count", 32'(cur_count), 32'(VEC[k][15:0]));
    end

    // terminal count, no autoinit
    do_load(1'b0, 1'b0, 8'hA5, 16'h0040, 16'h0001);
    do_steps(1);
    step = 1; #1;
    chk("R6 tc on final", 32'(tc), 1);
    chk("R6 final address", 32'(phys_addr), 32'hA50041);
    @(negedge clk); step = 0;
    chk("R6 tc single", 32'(tc), 0);
    chk("R7 count ffff", 32'(cur_count), 32'hFFFF);
    chk("R7 masked", 32'(active), 0);
    do_steps(2);
    chk("R7 count held", 32'(cur_count), 32'hFFFF);
    chk("R7 addr held", 32'(phys_addr), 32'hA50042);

    // autoinit, single transfer
    do_load(1'b1, 1'b1, 8'h11, 16'h0100, 16'h0000);
    step = 1; #1;
    chk("R8 tc first step", 32'(tc), 1);
    @(negedge clk); step = 0;
    chk("R8 count reloaded", 32'(cur_count), 0);
    chk("R8 addr reloaded", 32'(phys_addr), 32'h100200);
    chk("R8 stays active", 32'(active), 1);

    // load beats step
    do_load(1'b0, 1'b0, 8'h00, 16'h0000, 16'h0009);
    step = 1; load = 1; base_count = 16'h0020; base_addr = 16'h0300;
    @(negedge clk); step = 0; load = 0;
    chk("R9 count from load", 32'(cur_count), 32'h0020);
    chk("R9 addr from load", 32'(phys_addr), 32'h000300);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule